// File: doc/BRIEF.md
# Clock Output Divider Synchronizer

This block drives a bank of integer clock dividers from one fast clock and restarts them in phase on demand. A restart can come from three sources: the active-low asynchronous `sync_n` pin, the software level `sw_hold`, or a write of a new divide value through the `div_wr` strobe. Any of these holds every divider in reset with its output low. When the hold ends, all dividers start on the same fast-clock cycle.

The release can take one of two timing paths. When `tight_en` is 1 and `sync_direct` is 0, the release waits for the next rising edge of `ref_clk`, so the restarted outputs line up with the reference as well as with each other. In every other setting the release is taken from the end of the hold itself. After the release gate opens, a two-stage rising-edge pipeline is followed by a falling-edge output stage. This adds a fixed two and a half fast-clock cycles.

Top module: `clkout_sync_bank`

## Requirements
- R1: While `rst_n` is low, every bit of `clk_out` is low.
- R2: Within six rising `clk` edges after `sync_n` falls or `sw_hold` rises, every `clk_out` bit is low, and it stays low for as long as the hold lasts.
- R3: With `tight_en`=1 and `sync_direct`=1, after `sync_n` rises the first `clk_out` rising edge falls on the falling `clk` edge that follows the fifth rising `clk` edge after the change.
- R4: With `tight_en`=1 and `sync_direct`=0, the release waits for the first rise of `ref_clk` at or after the end of the hold. The first `clk_out` rising edge then falls on the falling `clk` edge after the fifth rising `clk` edge that follows that `ref_clk` rise.
- R5: With `tight_en`=0, the latency of R3 applies whatever the value of `sync_direct` and of `ref_clk`.
- R6: Releasing `sw_hold` (1 to 0) has the same effect and latency as a rise of `sync_n`, in both timing paths.
- R7: A single-cycle `div_wr` pulse stores `div_val` into the divider chosen by `div_sel` (0 is `clk_out[0]`). It also restarts the whole bank: every output is low after the fourth and fifth rising edges that follow the strobe, and (in the direct path) rises again after the sixth.
- R8: After every release, all `clk_out` bits have their first rising edge in the same fast-clock cycle.
- R9: Output i has a period of N_i fast cycles, starting high for floor(N_i/2) cycles. N_i is the stored value, with 0 and 1 acting as 2. The reset values are N_i = 2 + i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock (divided VCO) |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk | input | 1 | Reference clock used for the re-timed release |
| sync_n | input | 1 | Asynchronous sync request, low holds the bank |
| sw_hold | input | 1 | Software hold request, high holds the bank |
| tight_en | input | 1 | Enables the controlled re-timing path |
| sync_direct | input | 1 | 1 bypasses the reference re-timing |
| div_wr | input | 1 | Divide-value write strobe |
| div_sel | input | SEL_W (2) | Index of the divider written |
| div_val | input | DIV_W (8) | New divide value |
| clk_out | output | NUM_OUT (4) | Divided output clocks |

## Verification
The hardest case to reach from the ports is a release that must wait for a reference edge arriving several cycles after the hold ends, or arriving in the same cycle as the release. A hold is taken while `ref_clk` stays low long enough to clear its synchronizer. The release and the single `ref_clk` rise are then placed at chosen cycle offsets, so the measured latency separates waiting for the edge from releasing directly. Divider writes are made while the bank is running, which shows that outputs already toggling are forced low and restarted together.

// File: rtl/clkdiv_sync_pkg.sv
// Package: shared helpers for the divider synchronizer.
// Assumes divide values are unsigned integers; values below 2 act as 2.
package clkdiv_sync_pkg;

    // Map a stored divide value onto the effective value actually used.
    function automatic logic [15:0] eff_div(input logic [15:0] raw);
        return (raw < 16'd2) ? 16'd2 : raw;
    endfunction

endpackage

// File: rtl/out_hold_ctrl.sv
// Module: out_hold_ctrl
// Combines the pin request, the software request and divider writes into
// one hold level in the fast clock domain.
// Assumes sync_n and sw_hold are asynchronous; div_wr is synchronous to clk.
module out_hold_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int WR_HOLD     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_n,
    input  logic sw_hold,
    input  logic div_wr,
    output logic hold_all
);
    localparam int CNT_W = $clog2(WR_HOLD + 1);

    logic [SYNC_STAGES-1:0] req_pipe;
    logic [CNT_W-1:0]       wr_cnt;
    logic                   req_raw;

    // Active-high request from either asynchronous source.
    assign req_raw = ~sync_n | sw_hold;

    // Bring the request into the fast domain; reset counts as a hold.
    always_ff @(posedge clk) begin
        if (!rst_n) req_pipe <= '1;
        else        req_pipe <= {req_pipe[SYNC_STAGES-2:0], req_raw};
    end

    // Stretch each divider write into a hold of WR_HOLD cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)           wr_cnt <= '0;
        else if (div_wr)      wr_cnt <= CNT_W'(WR_HOLD);
        else if (wr_cnt != 0) wr_cnt <= wr_cnt - 1'b1;
    end

    // Final hold level seen by the release logic.
    assign hold_all = req_pipe[SYNC_STAGES-1] | (wr_cnt != '0);

    // A write must hold the bank for at least two cycles.
    p_wr_hold_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr |=> hold_all ##1 hold_all);

endmodule

// File: rtl/sync_release_timer.sv
// Module: sync_release_timer
// Opens the release gate when the hold ends, either at once or on the next
// reference rising edge, then delays it by a fixed rising-edge pipeline.
// Assumes ref_clk is much slower than clk and is sampled by a synchronizer.
module sync_release_timer #(
    parameter int REF_STAGES = 2,
    parameter int LAT_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_clk,
    input  logic hold_all,
    input  logic tight_en,
    input  logic sync_direct,
    output logic run_en
);
    logic [REF_STAGES:0]   ref_pipe;
    logic [LAT_STAGES-1:0] lat_pipe;
    logic                  ref_edge;
    logic                  use_ref;
    logic                  gate_q;

    // Sample the reference and keep one extra stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_pipe <= '0;
        else        ref_pipe <= {ref_pipe[REF_STAGES-1:0], ref_clk};
    end

    assign ref_edge = ref_pipe[REF_STAGES-1] & ~ref_pipe[REF_STAGES];
    assign use_ref  = tight_en & ~sync_direct;

    // Release gate: closes on hold, opens directly or on a reference edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                    gate_q <= 1'b1;
        else if (hold_all)             gate_q <= 1'b1;
        else if (!use_ref || ref_edge) gate_q <= 1'b0;
    end

    // Fixed-latency pipeline between the gate and the dividers.
    always_ff @(posedge clk) begin
        if (!rst_n) lat_pipe <= '0;
        else        lat_pipe <= {lat_pipe[LAT_STAGES-2:0], ~gate_q};
    end

    assign run_en = lat_pipe[LAT_STAGES-1];

    // Dividers start only two cycles after the gate opened.
    p_release_pipe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_en) |-> $past(!gate_q, 2));

    // In the re-timed path the gate opens only on a reference edge.
    p_ref_retime_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(gate_q) && $past(use_ref))
        |-> ($past(ref_pipe[REF_STAGES-1]) && !$past(ref_pipe[REF_STAGES])));

endmodule

// File: rtl/out_clk_divider.sv
// Module: out_clk_divider
// One integer divider: stores its divide value and, while run_en is high,
// counts on the falling clock edge, giving the final half-cycle of latency.
// Assumes run_en comes from a rising-edge register.
module out_clk_divider #(
    parameter int DIV_W   = 8,
    parameter int DEF_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wr_val,
    input  logic             run_en,
    output logic             clk_o
);
    import clkdiv_sync_pkg::*;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] eff;
    logic [DIV_W-1:0] half;
    logic             out_q;

    // Stored divide value, loaded by a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     div_q <= DIV_W'(DEF_DIV);
        else if (wr_en) div_q <= wr_val;
    end

    // Effective divide value and length of the high phase.
    always_comb begin
        eff  = DIV_W'(eff_div(16'(div_q)));
        half = eff >> 1;
    end

    // Falling-edge counter and output flop; cleared while not running.
    always_ff @(negedge clk) begin
        if (!rst_n || !run_en) begin
            cnt_q <= '0;
            out_q <= 1'b0;
        end else begin
            out_q <= (cnt_q < half);
            cnt_q <= (cnt_q >= eff - 1'b1) ? '0 : cnt_q + 1'b1;
        end
    end

    assign clk_o = out_q;

    // A divider that is not running keeps its output low.
    p_held_out_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> !clk_o);

endmodule

// File: rtl/clkout_sync_bank.sv
// Module: clkout_sync_bank (top)
// Bank of NUM_OUT output dividers restarted in phase by a pin request, a
// software request or a divide-value write. The release is taken directly
// or re-timed to ref_clk, then delayed by a fixed 2.5 fast cycles.
// Assumes clk is the fast divided-VCO clock; rst_n is synchronous.
module clkout_sync_bank #(
    parameter int NUM_OUT  = 4,
    parameter int DIV_W    = 8,
    parameter int DEF_BASE = 2,
    parameter int WR_HOLD  = 2,
    parameter int SEL_W    = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_clk,
    input  logic               sync_n,
    input  logic               sw_hold,
    input  logic               tight_en,
    input  logic               sync_direct,
    input  logic               div_wr,
    input  logic [SEL_W-1:0]   div_sel,
    input  logic [DIV_W-1:0]   div_val,
    output logic [NUM_OUT-1:0] clk_out
);
    logic hold_all;
    logic run_en;

    // Request combining and write stretching.
    out_hold_ctrl #(
        .SYNC_STAGES(2),
        .WR_HOLD    (WR_HOLD)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_n  (sync_n),
        .sw_hold (sw_hold),
        .div_wr  (div_wr),
        .hold_all(hold_all)
    );

    // Release re-timing and fixed-latency pipeline.
    sync_release_timer #(
        .REF_STAGES(2),
        .LAT_STAGES(2)
    ) u_rel (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_clk    (ref_clk),
        .hold_all   (hold_all),
        .tight_en   (tight_en),
        .sync_direct(sync_direct),
        .run_en     (run_en)
    );

    // One divider per output, all sharing the same run enable.
    for (genvar gi = 0; gi < NUM_OUT; gi++) begin : g_div
        out_clk_divider #(
            .DIV_W  (DIV_W),
            .DEF_DIV(DEF_BASE + gi)
        ) u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (div_wr && (div_sel == SEL_W'(gi))),
            .wr_val(div_val),
            .run_en(run_en),
            .clk_o (clk_out[gi])
        );
    end

    // Outputs stay low during reset.
    always @(posedge clk) begin
        if (!rst_n && $past(!rst_n)) begin
            p_reset_low_r1: assert (clk_out == '0);
        end
    end

endmodule

// File: tb/clkout_sync_bank_test.sv
`timescale 1ns/1ps
module clkout_sync_bank_test;
    localparam int NO = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_clk = 1'b0;
    logic          sync_n = 1'b1;
    logic          sw_hold = 1'b0;
    logic          tight_en = 1'b1;
    logic          sync_direct = 1'b1;
    logic          div_wr = 1'b0;
    logic [1:0]    div_sel = '0;
    logic [7:0]    div_val = '0;
    logic [NO-1:0] clk_out;

    int total = 0;
    int fails = 0;
    int nvals [NO];

    always #2.5 clk = ~clk;

    clkout_sync_bank uut (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .sync_n(sync_n),
        .sw_hold(sw_hold), .tight_en(tight_en), .sync_direct(sync_direct),
        .div_wr(div_wr), .div_sel(div_sel), .div_val(div_val),
        .clk_out(clk_out)
    );

    typedef struct packed {
        logic tight;
        logic direct;
        logic use_sw;
        int   ref_at;   // drive index of the single ref rise, -1 for none
        int   exp_k;    // rising edge after which outputs first rise
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 1'b1, 1'b0, -1,  5},   // R3 direct
        '{1'b1, 1'b0, 1'b0,  6, 11},   // R4 late ref edge
        '{1'b1, 1'b0, 1'b0,  0,  5},   // R4 ref edge with release
        '{1'b0, 1'b0, 1'b0,  9,  5},   // R5 tight path off
        '{1'b1, 1'b0, 1'b1,  3,  8},   // R6 software, re-timed
        '{1'b1, 1'b1, 1'b1, -1,  5}    // R6 software, direct
    };

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Samples 4 ns after each rising edge, i.e. after the falling edge.
    task automatic measure(input int exp_k, input int quiet_from,
                           input int ref_at, input string req);
        int first = -1;
        int bad = 0;
        logic [NO-1:0] s;
        for (int k = 1; k <= exp_k + 16; k++) begin
            @(posedge clk); #1;
            if (k == 1) div_wr = 1'b0;
            if (k == ref_at) ref_clk = 1'b1;
            #3;
            s = clk_out;
            if (first < 0) begin
                if (k >= quiet_from && s != '0) begin
                    first = k;
                    check(first == exp_k, req, "first rise edge", first, exp_k);
                    check(s == '1, "R8", "outputs aligned", int'(s), (1 << NO) - 1);
                end
            end else begin
                for (int i = 0; i < NO; i++) begin
                    if (s[i] != (((k - first) % nvals[i]) < (nvals[i] / 2)))
                        bad++;
                end
            end
        end
        if (first < 0) check(1'b0, req, "no output rise", -1, exp_k);
        check(bad == 0, "R9", "divide pattern mismatches", bad, 0);
    endtask

    task automatic write_div(input int sel, input int val, input string req);
        @(posedge clk); #1;
        tight_en = 1'b1; sync_direct = 1'b1;
        div_sel = 2'(sel); div_val = 8'(val); div_wr = 1'b1;
        nvals[sel] = (val < 2) ? 2 : val;
        measure(6, 4, -1, req);
    endtask

    initial begin
        for (int i = 0; i < NO; i++) nvals[i] = 2 + i;
        repeat (4) @(posedge clk);
        #4;
        check(clk_out == '0, "R1", "outputs in reset", int'(clk_out), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        foreach (VECS[v]) begin
            string tag;
            tag = !VECS[v].tight ? "R5" : VECS[v].use_sw ? "R6" :
                  VECS[v].direct ? "R3" : "R4";
            @(posedge clk); #1;
            ref_clk = 1'b0;
            tight_en = VECS[v].tight;
            sync_direct = VECS[v].direct;
            if (VECS[v].use_sw) sw_hold = 1'b1; else sync_n = 1'b0;
            repeat (9) @(posedge clk);
            #4;
            check(clk_out == '0, "R2", "outputs during hold", int'(clk_out), 0);
            @(posedge clk); #1;
            sync_n = 1'b1; sw_hold = 1'b0;
            if (VECS[v].ref_at == 0) ref_clk = 1'b1;
            measure(VECS[v].exp_k, 1, VECS[v].ref_at, tag);
        end

        // R7: writes restart the running bank with new values.
        write_div(3, 6, "R7");
        // R9: values below 2 behave as 2.
        write_div(0, 1, "R9");
        write_div(1, 0, "R7");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(5ns * 150000);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule